// File: doc/BRIEF.md
# CAN Error Counters with Warning Flag

This block keeps the transmit and receive error counts of a CAN controller and raises one warning flag when either count gets high. The protocol logic around it decides which bus event changes which count and by how much. It delivers that decision as increment and decrement strobes, one pair per counter, each pair with its own step size. The warning threshold is picked by a select bit. With the bit at 0 the test is "strictly above 96". With the bit at 1 the test is "128 or more". The flag is the OR of the two counter tests.

Software can load either counter only while the controller is in init mode. Writes made outside init mode are dropped. Entering init mode leaves both counts as they are. A software write takes priority over a hardware strobe to the same counter in the same cycle.

The transmit counter is driven by a two-state machine:
- `TX_RUN` is normal counting.
- `TX_BUSOFF` holds the count at 256.

There are two transitions:
- The *overflow* transition (`TX_RUN` to `TX_BUSOFF`) fires when an increment would take the transmit count past 255. On that transition a one-cycle bus-off pulse goes to the outside controller.
- The *recovery* transition (`TX_BUSOFF` to `TX_RUN`) fires on the recovery-done input. It clears both counters to 0.

Top module: `can_err_warn`

## Requirements
- R1: After reset both counts are 0, the warning flag is 0 and the bus-off pulse is 0.
- R2: In each counter, an increment strobe on its own adds the step, and a decrement strobe on its own subtracts the step. When both strobes of one counter are high together, that counter holds its value.
- R3: With `warn_sel_i` = 0, `warn_o` is 1 exactly when the transmit count or the receive count is above 96. A count of 96 gives 0 and a count of 97 gives 1.
- R4: With `warn_sel_i` = 1, `warn_o` is 1 exactly when either count is at least 128. A count of 127 gives 0 and a count of 128 gives 1.
- R5: `warn_o` depends only on the registered counts and `warn_sel_i`. It changes in the same cycle the count changes, with no extra register delay.
- R6: A software write (`*_wr_i`) takes effect only when `init_i` = 1, and is ignored when `init_i` = 0. Raising `init_i` does not change either count.
- R7: When a software write is accepted in the same cycle as a strobe to that counter, the written value is loaded and the strobe is ignored.
- R8: A decrement never takes a count below 0. The receive count saturates at 255.
- R9: When an increment would take the transmit count above 255, the transmit count becomes 256. In the same cycle `busoff_o` is 1 for exactly one cycle, and the state moves from `TX_RUN` to `TX_BUSOFF`.
- R10: In `TX_BUSOFF` the transmit count stays at 256, whatever strobes or writes arrive. `recov_i` = 1 sets both counts to 0 and returns to `TX_RUN`. Recovery takes priority over a write or strobe on the receive counter.
- R11: `recov_i` has no effect in `TX_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_inc_i | input | 1 | Transmit count increment strobe |
| tx_dec_i | input | 1 | Transmit count decrement strobe |
| tx_step_i | input | 4 | Step size for the transmit strobes |
| rx_inc_i | input | 1 | Receive count increment strobe |
| rx_dec_i | input | 1 | Receive count decrement strobe |
| rx_step_i | input | 4 | Step size for the receive strobes |
| init_i | input | 1 | Init mode; enables software writes |
| tx_wr_i | input | 1 | Software write to the transmit count |
| tx_wdata_i | input | 8 | Value for the transmit write |
| rx_wr_i | input | 1 | Software write to the receive count |
| rx_wdata_i | input | 8 | Value for the receive write |
| warn_sel_i | input | 1 | Threshold select: 0 means above 96, 1 means at least 128 |
| recov_i | input | 1 | Bus-off recovery done |
| tx_cnt_o | output | 9 | Transmit error count (256 while bus-off) |
| rx_cnt_o | output | 8 | Receive error count |
| warn_o | output | 1 | Warning flag |
| busoff_o | output | 1 | One-cycle pulse on entering bus-off |

## Verification
The bench aims at both threshold edges in both modes (96/97 and 127/128), so that an off-by-one comparison or swapped modes shows up as a wrong flag. It drives the transmit count from 250 past 255 to catch a counter that wraps or fails to pulse. It also sends strobes and writes during bus-off, which a design that leaks updates would let move the held 256. Further cases cover a write colliding with a strobe, writes made with init low, recovery sent while running, and decrements below zero. A design that got priority or saturation wrong would load the strobe result, accept the write, clear the counts, or wrap to a large value.

// File: rtl/can_errc_pkg.sv
package can_errc_pkg;

    typedef enum logic [0:0] {
        TX_RUN    = 1'b0,
        TX_BUSOFF = 1'b1
    } tx_state_e;

    typedef enum logic [0:0] {
        WARN_GT_LO = 1'b0,
        WARN_GE_HI = 1'b1
    } warn_mode_e;

    localparam int unsigned NUM_CNT = 2;

endpackage

// File: rtl/errc_rx_counter.sv
module errc_rx_counter #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              wr_en_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic              clr_i,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] step_ext;

    assign step_ext = {{(CNT_W-STEP_W){1'b0}}, step_i};
    assign sum      = {1'b0, cnt_q} + {1'b0, step_ext};

    // recovery first, then software write, then strobes
    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (wr_en_i) begin
            cnt_d = wdata_i;
        end else if (inc_i && !dec_i) begin
            if (sum > CNT_MAX) begin
                cnt_d = CNT_MAX[CNT_W-1:0];
            end else begin
                cnt_d = sum[CNT_W-1:0];
            end
        end else if (dec_i && !inc_i) begin
            if (cnt_q < step_ext) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q - step_ext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/errc_tx_fsm.sv
module errc_tx_fsm
    import can_errc_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              wr_en_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic              recov_i,
    output logic [CNT_W:0]    cnt_o,
    output logic              busoff_pulse_o,
    output logic              recov_clr_o,
    output tx_state_e         state_o
);

    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W:0] CNT_BO  = {1'b1, {CNT_W{1'b0}}};

    tx_state_e      state_q;
    tx_state_e      state_d;
    logic [CNT_W:0] cnt_q;
    logic [CNT_W:0] cnt_d;
    logic           pulse_q;
    logic           pulse_d;
    logic           clr_d;
    logic [CNT_W:0] step_ext;
    logic [CNT_W:0] sum;

    assign step_ext = {{(CNT_W+1-STEP_W){1'b0}}, step_i};
    // in TX_RUN cnt_q <= CNT_MAX, so the sum fits CNT_W+1 bits
    assign sum      = cnt_q + step_ext;

    // next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pulse_d = 1'b0;
        clr_d   = 1'b0;
        unique case (state_q)
            TX_RUN: begin
                if (wr_en_i) begin
                    cnt_d = {1'b0, wdata_i};
                end else if (inc_i && !dec_i) begin
                    if (sum > CNT_MAX) begin
                        cnt_d   = CNT_BO;
                        state_d = TX_BUSOFF;
                        pulse_d = 1'b1;
                    end else begin
                        cnt_d = sum;
                    end
                end else if (dec_i && !inc_i) begin
                    if (cnt_q < step_ext) begin
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q - step_ext;
                    end
                end
            end
            TX_BUSOFF: begin
                if (recov_i) begin
                    cnt_d   = '0;
                    state_d = TX_RUN;
                    clr_d   = 1'b1;
                end
            end
            default: begin
                state_d = TX_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_RUN;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pulse_q <= pulse_d;
        end
    end

    // outputs
    always_comb begin
        cnt_o          = cnt_q;
        busoff_pulse_o = pulse_q;
        recov_clr_o    = clr_d;
        state_o        = state_q;
    end

endmodule

// File: rtl/errc_warn_cmp.sv
module errc_warn_cmp
    import can_errc_pkg::*;
#(
    parameter int unsigned W     = 9,
    parameter int unsigned LO_TH = 96,
    parameter int unsigned HI_TH = 128
) (
    input  logic [W-1:0] cnt_i,
    input  warn_mode_e   mode_i,
    output logic         over_o
);

    localparam logic [W-1:0] LO_V = W'(LO_TH);
    localparam logic [W-1:0] HI_V = W'(HI_TH);

    always_comb begin
        unique case (mode_i)
            WARN_GT_LO: over_o = (cnt_i >  LO_V);
            WARN_GE_HI: over_o = (cnt_i >= HI_V);
            default:    over_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/can_err_warn.sv
module can_err_warn
    import can_errc_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned STEP_W = 4,
    parameter int unsigned LO_TH = 96,
    parameter int unsigned HI_TH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_inc_i,
    input  logic              tx_dec_i,
    input  logic [STEP_W-1:0] tx_step_i,
    input  logic              rx_inc_i,
    input  logic              rx_dec_i,
    input  logic [STEP_W-1:0] rx_step_i,
    input  logic              init_i,
    input  logic              tx_wr_i,
    input  logic [CNT_W-1:0]  tx_wdata_i,
    input  logic              rx_wr_i,
    input  logic [CNT_W-1:0]  rx_wdata_i,
    input  logic              warn_sel_i,
    input  logic              recov_i,
    output logic [CNT_W:0]    tx_cnt_o,
    output logic [CNT_W-1:0]  rx_cnt_o,
    output logic              warn_o,
    output logic              busoff_o
);

    localparam int unsigned CMP_W = CNT_W + 1;

    logic                 recov_clr;
    tx_state_e            tx_state;
    logic [CNT_W:0]       tx_cnt;
    logic [CNT_W-1:0]     rx_cnt;
    logic [NUM_CNT-1:0]   over;
    logic [CMP_W-1:0]     cmp_in [NUM_CNT];
    warn_mode_e           mode;

    assign mode = warn_mode_e'(warn_sel_i);

    errc_tx_fsm #(
        .CNT_W  (CNT_W),
        .STEP_W (STEP_W)
    ) u_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .inc_i          (tx_inc_i),
        .dec_i          (tx_dec_i),
        .step_i         (tx_step_i),
        .wr_en_i        (init_i && tx_wr_i),
        .wdata_i        (tx_wdata_i),
        .recov_i        (recov_i),
        .cnt_o          (tx_cnt),
        .busoff_pulse_o (busoff_o),
        .recov_clr_o    (recov_clr),
        .state_o        (tx_state)
    );

    errc_rx_counter #(
        .CNT_W  (CNT_W),
        .STEP_W (STEP_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (rx_inc_i),
        .dec_i   (rx_dec_i),
        .step_i  (rx_step_i),
        .wr_en_i (init_i && rx_wr_i),
        .wdata_i (rx_wdata_i),
        .clr_i   (recov_clr),
        .cnt_o   (rx_cnt)
    );

    assign cmp_in[0] = tx_cnt;
    assign cmp_in[1] = {1'b0, rx_cnt};

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cmp
        errc_warn_cmp #(
            .W     (CMP_W),
            .LO_TH (LO_TH),
            .HI_TH (HI_TH)
        ) u_cmp (
            .cnt_i  (cmp_in[g]),
            .mode_i (mode),
            .over_o (over[g])
        );
    end

    assign warn_o   = |over;
    assign tx_cnt_o = tx_cnt;
    assign rx_cnt_o = rx_cnt;

endmodule

// File: rtl/can_err_warn_chk.sv
module can_err_warn_chk #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned STEP_W = 4,
    parameter int unsigned LO_TH = 96,
    parameter int unsigned HI_TH = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_inc_i,
    input logic              tx_dec_i,
    input logic              rx_inc_i,
    input logic              rx_dec_i,
    input logic              init_i,
    input logic              rx_wr_i,
    input logic [CNT_W-1:0]  rx_wdata_i,
    input logic              warn_sel_i,
    input logic              recov_i,
    input logic [CNT_W:0]    tx_cnt_o,
    input logic [CNT_W-1:0]  rx_cnt_o,
    input logic              warn_o,
    input logic              busoff_o
);

    localparam logic [CNT_W:0]   BO_V  = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W-1:0] RXMAX = {CNT_W{1'b1}};
    localparam logic [CNT_W:0]   LO_V  = (CNT_W+1)'(LO_TH);
    localparam logic [CNT_W:0]   HI_V  = (CNT_W+1)'(HI_TH);

    logic in_bo;
    assign in_bo = (tx_cnt_o == BO_V);

    a_r3_gt_lo_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!warn_sel_i && warn_o) |-> ((tx_cnt_o > LO_V) || ({1'b0, rx_cnt_o} > LO_V)));

    a_r4_ge_hi_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_sel_i && ((tx_cnt_o >= HI_V) || ({1'b0, rx_cnt_o} >= HI_V))) |-> warn_o);

    a_r6_no_stray_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !tx_inc_i && !tx_dec_i && !recov_i) |=> $stable(tx_cnt_o));

    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && rx_wr_i && !(in_bo && recov_i)) |=> (rx_cnt_o == $past(rx_wdata_i)));

    a_r8_rx_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_cnt_o == RXMAX) && rx_inc_i && !rx_dec_i && !(init_i && rx_wr_i)
         && !(in_bo && recov_i)) |=> (rx_cnt_o == RXMAX));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_o |=> !busoff_o);

    a_r9_pulse_at_bo: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_o |-> in_bo);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bo && !recov_i) |=> in_bo);

    a_r10_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bo && recov_i) |=> ((tx_cnt_o == '0) && (rx_cnt_o == '0)));

    always_comb begin
        if (rst_n) begin
            a_r10_ceiling: assert (tx_cnt_o <= BO_V);
        end
    end

endmodule

bind can_err_warn can_err_warn_chk #(
    .CNT_W  (CNT_W),
    .STEP_W (STEP_W),
    .LO_TH  (LO_TH),
    .HI_TH  (HI_TH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_inc_i   (tx_inc_i),
    .tx_dec_i   (tx_dec_i),
    .rx_inc_i   (rx_inc_i),
    .rx_dec_i   (rx_dec_i),
    .init_i     (init_i),
    .rx_wr_i    (rx_wr_i),
    .rx_wdata_i (rx_wdata_i),
    .warn_sel_i (warn_sel_i),
    .recov_i    (recov_i),
    .tx_cnt_o   (tx_cnt_o),
    .rx_cnt_o   (rx_cnt_o),
    .warn_o     (warn_o),
    .busoff_o   (busoff_o)
);

// File: tb/test_can_err_warn.sv
module test_can_err_warn;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_inc_i = 0, tx_dec_i = 0, rx_inc_i = 0, rx_dec_i = 0;
    logic [3:0] tx_step_i = 0, rx_step_i = 0;
    logic       init_i = 0, tx_wr_i = 0, rx_wr_i = 0, warn_sel_i = 0, recov_i = 0;
    logic [7:0] tx_wdata_i = 0, rx_wdata_i = 0;
    logic [8:0] tx_cnt_o;
    logic [7:0] rx_cnt_o;
    logic       warn_o, busoff_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    int  m_tx = 0, m_rx = 0;
    bit  m_bo_state = 0, m_pulse = 0;

    always #10 clk = ~clk;

    can_err_warn i_can_err_warn (
        .clk(clk), .rst_n(rst_n),
        .tx_inc_i(tx_inc_i), .tx_dec_i(tx_dec_i), .tx_step_i(tx_step_i),
        .rx_inc_i(rx_inc_i), .rx_dec_i(rx_dec_i), .rx_step_i(rx_step_i),
        .init_i(init_i), .tx_wr_i(tx_wr_i), .tx_wdata_i(tx_wdata_i),
        .rx_wr_i(rx_wr_i), .rx_wdata_i(rx_wdata_i), .warn_sel_i(warn_sel_i),
        .recov_i(recov_i), .tx_cnt_o(tx_cnt_o), .rx_cnt_o(rx_cnt_o),
        .warn_o(warn_o), .busoff_o(busoff_o)
    );

    function automatic int f_strobe(int c, bit inc, bit dec, int step, int cap);
        int r = c;
        if (inc && !dec) r = c + step;
        else if (dec && !inc) r = (c < step) ? 0 : c - step;
        if (r > cap) r = cap;
        return r;
    endfunction

    function automatic bit f_warn(int tx, int rx, bit sel);
        if (!sel) return (tx > 96) || (rx > 96);
        return (tx >= 128) || (rx >= 128);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // apply current inputs for one clock, update model, compare at negedge
    task automatic tick(string req);
        bit clr = 0;
        m_pulse = 0;
        if (m_bo_state) begin
            if (recov_i) begin
                m_bo_state = 0; m_tx = 0; clr = 1;
            end
        end else if (init_i && tx_wr_i) begin
            m_tx = tx_wdata_i;
        end else begin
            int t = f_strobe(m_tx, tx_inc_i, tx_dec_i, tx_step_i, 1000);
            if (t > 255) begin
                m_tx = 256; m_bo_state = 1; m_pulse = 1;
            end else m_tx = t;
        end
        if (clr) m_rx = 0;
        else if (init_i && rx_wr_i) m_rx = rx_wdata_i;
        else m_rx = f_strobe(m_rx, rx_inc_i, rx_dec_i, rx_step_i, 255);
        @(posedge clk);
        @(negedge clk);
        chk({req, " tx"}, tx_cnt_o, m_tx);
        chk({req, " rx"}, rx_cnt_o, m_rx);
        chk(warn_sel_i ? "R4 warn" : "R3 warn", warn_o, f_warn(m_tx, m_rx, warn_sel_i));
        chk("R9 busoff", busoff_o, m_pulse);
    endtask

    task automatic idle();
        tx_inc_i = 0; tx_dec_i = 0; rx_inc_i = 0; rx_dec_i = 0;
        init_i = 0; tx_wr_i = 0; rx_wr_i = 0; recov_i = 0;
    endtask

    task automatic load(int tx, int rx);
        idle();
        init_i = 1; tx_wr_i = 1; rx_wr_i = 1;
        tx_wdata_i = 8'(tx); rx_wdata_i = 8'(rx);
        tick("R6 load");
        idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tx", tx_cnt_o, 0);
        chk("R1 rx", rx_cnt_o, 0);
        chk("R1 warn", warn_o, 0);
        chk("R1 busoff", busoff_o, 0);
        rst_n = 1;
        @(negedge clk);

        // R3 thresholds, mode 0
        warn_sel_i = 0;
        load(96, 0);  chk("R3 96 tx", warn_o, 0);
        load(97, 0);  chk("R3 97 tx", warn_o, 1);
        load(0, 96);  chk("R3 96 rx", warn_o, 0);
        load(0, 97);  chk("R3 97 rx", warn_o, 1);
        // R4 thresholds, mode 1
        warn_sel_i = 1;
        load(127, 0); chk("R4 127 tx", warn_o, 0);
        load(128, 0); chk("R4 128 tx", warn_o, 1);
        load(0, 127); chk("R4 127 rx", warn_o, 0);
        load(0, 128); chk("R4 128 rx", warn_o, 1);

        // R5 same-cycle flag update
        warn_sel_i = 0;
        load(96, 10);
        tx_inc_i = 1; tx_step_i = 1;
        tick("R5");
        chk("R5 warn rises with count", warn_o, 1);
        idle();

        // R2 both strobes hold, single strobes step
        tx_inc_i = 1; tx_dec_i = 1; rx_inc_i = 1; rx_dec_i = 1; tx_step_i = 5; rx_step_i = 5;
        tick("R2 both");
        chk("R2 both hold", tx_cnt_o, 97);
        idle(); rx_dec_i = 1; rx_step_i = 3; tick("R2 dec");
        chk("R2 rx dec", rx_cnt_o, 7);

        // R6 write ignored outside init, init entry keeps counts
        idle(); tx_wr_i = 1; rx_wr_i = 1; tx_wdata_i = 3; rx_wdata_i = 200;
        tick("R6 noinit");
        chk("R6 write ignored", rx_cnt_o, 7);
        idle(); init_i = 1; tick("R6 init");
        chk("R6 init keeps", tx_cnt_o, 97);

        // R7 write beats strobe
        idle(); init_i = 1; tx_wr_i = 1; tx_wdata_i = 40; tx_inc_i = 1; tx_step_i = 9;
        rx_wr_i = 1; rx_wdata_i = 50; rx_dec_i = 1; rx_step_i = 9;
        tick("R7");
        chk("R7 tx written", tx_cnt_o, 40);
        chk("R7 rx written", rx_cnt_o, 50);

        // R8 saturation both ends
        load(2, 250);
        tx_dec_i = 1; tx_step_i = 7; rx_inc_i = 1; rx_step_i = 15;
        tick("R8");
        chk("R8 tx floor", tx_cnt_o, 0);
        chk("R8 rx ceiling", rx_cnt_o, 255);

        // R11 recovery while running
        idle(); recov_i = 1; tick("R11");
        chk("R11 no effect", rx_cnt_o, 255);

        // R9 overflow into bus-off
        load(250, 20);
        tx_inc_i = 1; tx_step_i = 10;
        tick("R9");
        chk("R9 tx 256", tx_cnt_o, 256);
        chk("R9 pulse", busoff_o, 1);
        idle(); tick("R9 after");
        chk("R9 pulse ends", busoff_o, 0);

        // R10 hold and recover
        tx_dec_i = 1; tx_step_i = 15; init_i = 1; tx_wr_i = 1; tx_wdata_i = 5;
        tick("R10 hold");
        chk("R10 held", tx_cnt_o, 256);
        idle(); tx_inc_i = 1; tx_step_i = 15; tick("R10 hold2");
        chk("R10 held inc", tx_cnt_o, 256);
        idle(); recov_i = 1; init_i = 1; rx_wr_i = 1; rx_wdata_i = 77;
        tick("R10 recov");
        chk("R10 tx zero", tx_cnt_o, 0);
        chk("R10 rx zero", rx_cnt_o, 0);
        idle();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            tx_inc_i   = ($urandom % 8) < 4;
            tx_dec_i   = ($urandom % 8) < 2;
            rx_inc_i   = ($urandom % 8) < 4;
            rx_dec_i   = ($urandom % 8) < 2;
            tx_step_i  = 4'($urandom);
            rx_step_i  = 4'($urandom);
            init_i     = ($urandom % 16) == 0;
            tx_wr_i    = ($urandom % 2) == 0;
            rx_wr_i    = ($urandom % 2) == 0;
            tx_wdata_i = 8'($urandom);
            rx_wdata_i = 8'($urandom);
            recov_i    = ($urandom % 12) == 0;
            if (($urandom % 32) == 0) warn_sel_i = ~warn_sel_i;
            tick("R2 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule